// File: doc/BRIEF.md
# GPIO Port Register Bank with Edge Events

This block is the run-time register window of a general-purpose I/O unit with 29 pins grouped into byte-wide ports. A host reaches it through a small byte-wide read/write port addressed by a 4-bit offset. Every port has a data-out register that the host can read back, so single bits can be changed by read-modify-write. Every port also has a data-in register that shows the synchronized pin levels. The two lowest ports also have an event-enable register and an event-status register. A status bit latches a rising edge of its pin while the matching enable bit is set. The host clears a status bit by writing 1 to it. An interrupt line is high while any enabled status bit is set.

A neighbouring configuration block supplies a per-pin output enable and a per-pin push-pull select. From these and the data-out bits this block computes each pin's drive value and drive enable. With push-pull selected, the pin drives the data-out value. Otherwise the pin works as open drain: it pulls low only when its data-out bit is 0 and is released when the bit is 1. Electrical pad behaviour is outside the block.

The block has no sequencing state machine. Its behaviour comes from per-port registers, a two-flop synchronizer, an edge detector and a registered read path. Host write strobes go straight to the selected register, and a read strobe loads the read-data register on the same edge.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset all data-out, event-enable and event-status registers are 0, `bus_rdata` is 0 and `evt_irq` is 0. With every output enable at 0, no pin is driven.
- R2: Data-out registers are read/write at offset 0x0 (pins 7..0), 0x4 (pins 15..8), 0x8 (pins 23..16) and 0xA (pins 28..24). Bit n of a register maps to the port's nth pin. For offset 0xA, bits 7..5 do not exist: they are not stored and read as 0.
- R3: Offsets 0x1, 0x5, 0x9 and 0xB return the pin levels of the same four ports through a two-flop synchronizer. A pin change that is set up before a clock edge is readable after the second edge. Bits 7..5 at 0xB read 0.
- R4: Event-enable registers are read/write at 0x2 (pins 7..0) and 0x6 (pins 15..8).
- R5: Event-status registers sit at 0x3 (pins 7..0) and 0x7 (pins 15..8). A status bit is set on the third clock edge after a low-to-high pin change, provided its enable bit is 1 at that edge.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall on the same edge, the set wins.
- R7: `evt_irq` is 1 exactly when some status bit and its matching enable bit are both 1. Clearing an enable bit masks that bit's interrupt but keeps its status.
- R8: When a pin's output enable is 0, its drive enable is 0. With push-pull at 1, the drive enable is 1 and the drive value follows data-out. With push-pull at 0, the drive enable equals the inverse of data-out and the drive value is 0.
- R9: Offsets 0xC..0xF read 0, and writes to them have no effect. Writes to data-in offsets also change nothing.
- R10: `bus_rdata` loads on an edge where `bus_rd` is 1 and otherwise holds. The value loaded is the register's content before any write on that same edge.
- R11: A rising edge while the enable bit is 0 does not set status, and a falling edge never sets status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears after the edge |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 29 | Raw pin levels |
| pin_oe_cfg | input | 29 | Per-pin output enable from configuration |
| pin_pp_cfg | input | 29 | Per-pin push-pull select (0 = open drain) |
| pin_drv | output | 29 | Pin drive value |
| pin_drv_en | output | 29 | Pin drive enable |
| evt_irq | output | 1 | OR of enabled status bits |

## Verification
The hardest case to reach is a status bit whose set and clear land on the same clock edge. To get there, the bench counts the synchronizer and edge-detector stages so that a write-1-to-clear strobe lands exactly on the third edge after a pin rises. It then reads the bit back, which should still be set. A behavioural model tracks the synchronizer delay as a shift of plain vectors and checks the read data, the drive outputs and the interrupt on every clock. It also covers reads and writes issued on the same edge to the same offset.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register kinds inside one port's window; value is the offset step.
    typedef enum logic [1:0] {
        RK_DOUT = 2'd0,
        RK_DIN  = 2'd1,
        RK_EVEN = 2'd2,
        RK_EVST = 2'd3
    } reg_kind_e;

    // Ports below evt_ports take four offsets each; the rest take two.
    function automatic int reg_off(input int port, input int kind, input int evt_ports);
        if (port < evt_ports)
            return port * 4 + kind;
        return evt_ports * 4 + (port - evt_ports) * 2 + kind;
    endfunction

    // Implemented bits of a port given the total pin count.
    function automatic int port_bits(input int port, input int pins, input int pw);
        int rem;
        rem = pins - port * pw;
        if (rem >= pw)
            return pw;
        return rem;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 29,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++)
                stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         en_wr,
    input  logic         sts_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] sts_q,
    output logic         pend
);
    logic [W-1:0] lvl_prev;
    logic [W-1:0] rise;
    logic [W-1:0] setv;
    logic [W-1:0] clrv;

    assign rise = lvl & ~lvl_prev;
    assign setv = rise & en_q;
    assign clrv = sts_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev <= '0;
            en_q     <= '0;
            sts_q    <= '0;
        end else begin
            lvl_prev <= lvl;
            if (en_wr)
                en_q <= wdata;
            // set has priority over a simultaneous write-1 clear
            sts_q <= (sts_q & ~clrv) | setv;
        end
    end

    assign pend = |(sts_q & en_q);

    AST_STS_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q & ~$past(sts_q) & ~($past(rise) & $past(en_q))) == '0); // R11

    AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clrv) & ~($past(rise) & $past(en_q)) & sts_q) == '0); // R6
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
    parameter int N = 29
) (
    input  logic [N-1:0] dout,
    input  logic [N-1:0] oe,
    input  logic [N-1:0] pp,
    output logic [N-1:0] drv,
    output logic [N-1:0] drv_en
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            drv[i] = pp[i] & dout[i];
            if (!oe[i])
                drv_en[i] = 1'b0;
            else if (pp[i])
                drv_en[i] = 1'b1;
            else
                drv_en[i] = ~dout[i];
        end
    end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 29,
    parameter int PORT_W      = 8,
    parameter int EVT_PORTS   = 2,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [PORT_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [PORT_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_oe_cfg,
    input  logic [NUM_PINS-1:0] pin_pp_cfg,
    output logic [NUM_PINS-1:0] pin_drv,
    output logic [NUM_PINS-1:0] pin_drv_en,
    output logic                evt_irq
);
    localparam int NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;
    localparam int PADDED    = NUM_PORTS * PORT_W;

    logic [NUM_PINS-1:0] din_sync;
    logic [PADDED-1:0]   din_pad;
    logic [PADDED-1:0]   dout_flat;
    logic [PORT_W-1:0]   dout_q  [NUM_PORTS];
    logic [PORT_W-1:0]   en_arr  [NUM_PORTS];
    logic [PORT_W-1:0]   sts_arr [NUM_PORTS];
    logic [NUM_PORTS-1:0] pend;
    logic [PORT_W-1:0]   rd_val;
    logic [PORT_W-1:0]   sts_any;

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_sync)
    );

    assign din_pad = PADDED'(din_sync);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int BITS = port_bits(p, NUM_PINS, PORT_W);
        localparam logic [PORT_W-1:0] MASK = PORT_W'((1 << BITS) - 1);
        localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(reg_off(p, int'(RK_DOUT), EVT_PORTS));
        localparam logic [ADDR_W-1:0] A_EVEN = ADDR_W'(reg_off(p, int'(RK_EVEN), EVT_PORTS));
        localparam logic [ADDR_W-1:0] A_EVST = ADDR_W'(reg_off(p, int'(RK_EVST), EVT_PORTS));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dout_q[p] <= '0;
            else if (bus_wr && bus_addr == A_DOUT)
                dout_q[p] <= bus_wdata & MASK;
        end

        if (p < EVT_PORTS) begin : g_evt
            gpio_evt_port #(.W(PORT_W)) u_evt (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl    (din_pad[p*PORT_W +: PORT_W]),
                .en_wr  (bus_wr && bus_addr == A_EVEN),
                .sts_wr (bus_wr && bus_addr == A_EVST),
                .wdata  (bus_wdata & MASK),
                .en_q   (en_arr[p]),
                .sts_q  (sts_arr[p]),
                .pend   (pend[p])
            );
        end else begin : g_plain
            assign en_arr[p]  = '0;
            assign sts_arr[p] = '0;
            assign pend[p]    = 1'b0;
        end
    end

    always_comb begin
        dout_flat = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            dout_flat[p*PORT_W +: PORT_W] = dout_q[p];
    end

    // Read decode: offsets that match no register fall through to zero.
    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(reg_off(p, int'(RK_DOUT), EVT_PORTS)))
                rd_val = dout_q[p];
            if (bus_addr == ADDR_W'(reg_off(p, int'(RK_DIN), EVT_PORTS)))
                rd_val = din_pad[p*PORT_W +: PORT_W];
            if (p < EVT_PORTS) begin
                if (bus_addr == ADDR_W'(reg_off(p, int'(RK_EVEN), EVT_PORTS)))
                    rd_val = en_arr[p];
                if (bus_addr == ADDR_W'(reg_off(p, int'(RK_EVST), EVT_PORTS)))
                    rd_val = sts_arr[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_val;
    end

    gpio_pad_ctl #(.N(NUM_PINS)) u_pad (
        .dout   (dout_flat[NUM_PINS-1:0]),
        .oe     (pin_oe_cfg),
        .pp     (pin_pp_cfg),
        .drv    (pin_drv),
        .drv_en (pin_drv_en)
    );

    assign evt_irq = |pend;

    always_comb begin
        sts_any = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            sts_any = sts_any | sts_arr[p];
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |-> (sts_any != '0)); // R7

    AST_NO_DRIVE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_drv_en & ~pin_oe_cfg) == '0); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata)); // R10
endmodule

// File: tb/tb_gpio_port_bank.sv
module tb_gpio_port_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [28:0] pin_in = '0;
    logic [28:0] pin_oe_cfg = '0;
    logic [28:0] pin_pp_cfg = '0;
    logic [28:0] pin_drv;
    logic [28:0] pin_drv_en;
    logic        evt_irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_port_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe_cfg(pin_oe_cfg), .pin_pp_cfg(pin_pp_cfg),
        .pin_drv(pin_drv), .pin_drv_en(pin_drv_en), .evt_irq(evt_irq)
    );

    // Behavioural reference: sync delay line and register image as plain vectors.
    logic [31:0] m_s1, m_s2, m_prv, m_dout;
    logic [15:0] m_en, m_st;
    logic [7:0]  m_rdata;

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return m_dout[7:0];
            4'h1: return m_s2[7:0];
            4'h2: return m_en[7:0];
            4'h3: return m_st[7:0];
            4'h4: return m_dout[15:8];
            4'h5: return m_s2[15:8];
            4'h6: return m_en[15:8];
            4'h7: return m_st[15:8];
            4'h8: return m_dout[23:16];
            4'h9: return m_s2[23:16];
            4'hA: return m_dout[31:24];
            4'hB: return m_s2[31:24];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prv = '0; m_dout = '0;
            m_en = '0; m_st = '0; m_rdata = '0;
        end else begin
            logic [15:0] setv, clr;
            setv = (m_s2[15:0] & ~m_prv[15:0]) & m_en;
            clr = '0;
            if (bus_rd) m_rdata = m_read(bus_addr);
            if (bus_wr) begin
                case (bus_addr)
                    4'h0: m_dout[7:0]   = bus_wdata;
                    4'h4: m_dout[15:8]  = bus_wdata;
                    4'h8: m_dout[23:16] = bus_wdata;
                    4'hA: m_dout[31:24] = bus_wdata & 8'h1F;
                    4'h2: m_en[7:0]     = bus_wdata;
                    4'h6: m_en[15:8]    = bus_wdata;
                    4'h3: clr[7:0]      = bus_wdata;
                    4'h7: clr[15:8]     = bus_wdata;
                    default: ;
                endcase
            end
            m_st  = (m_st & ~clr) | setv;
            m_prv = m_s2;
            m_s2  = m_s1;
            m_s1  = {3'b000, pin_in};
        end
    end

    // Per-cycle comparison, late in the low phase.
    always @(negedge clk) begin
        #8;
        if (rst_n && !done) begin
            logic [28:0] e_en, e_drv;
            e_drv = m_dout[28:0] & pin_pp_cfg;
            e_en  = pin_oe_cfg & (pin_pp_cfg | ~m_dout[28:0]);
            tests++;
            if (bus_rdata !== m_rdata) begin
                fails++;
                $display("FAIL R10 rdata model: got %h exp %h", bus_rdata, m_rdata);
            end
            tests++;
            if (pin_drv_en !== e_en || pin_drv !== e_drv) begin
                fails++;
                $display("FAIL R8 drive model: got en %h drv %h exp en %h drv %h",
                         pin_drv_en, pin_drv, e_en, e_drv);
            end
            tests++;
            if (evt_irq !== |(m_st & m_en)) begin
                fails++;
                $display("FAIL R7 irq model: got %b exp %b", evt_irq, |(m_st & m_en));
            end
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        chk(32'(bus_rdata), 32'(exp), req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state
        chk(32'(bus_rdata), 0, "R1 rdata");
        chk(32'(evt_irq), 0, "R1 irq");
        chk(32'(pin_drv_en), 0, "R1 drive enable");
        rst_n = 1'b1;
        idle(2);
        rd_chk(4'h0, 8'h00, "R1 dout0 reset");
        rd_chk(4'h3, 8'h00, "R1 status0 reset");

        // R2: data-out read/write
        wr(4'h0, 8'hA5); wr(4'h4, 8'h3C); wr(4'h8, 8'hFF); wr(4'hA, 8'hFF);
        rd_chk(4'h0, 8'hA5, "R2 dout port0");
        rd_chk(4'h4, 8'h3C, "R2 dout port1");
        rd_chk(4'h8, 8'hFF, "R2 dout port2");
        rd_chk(4'hA, 8'h1F, "R2 dout port3 upper bits");

        // R8: drive control
        @(negedge clk);
        pin_oe_cfg = '1; pin_pp_cfg = 29'h0F0F0F0F & 29'h1FFFFFFF;
        #1;
        chk(32'(pin_drv_en[7:0]), 32'h5F, "R8 mixed push-pull and open drain");
        chk(32'(pin_drv[7:0]), 32'h05, "R8 drive value");
        @(negedge clk);
        pin_oe_cfg = 29'h0;
        #1;
        chk(32'(pin_drv_en), 0, "R8 oe off");
        pin_oe_cfg = 29'h1FFFFFFF;

        // R3: synchronized data-in, two-edge latency
        @(negedge clk);
        pin_in = 29'h1ABCDE5;
        @(negedge clk); #1;
        bus_addr = 4'h1;
        chk(32'(dut.bus_rdata), 32'(m_rdata), "R3 before second edge");
        idle(2);
        rd_chk(4'h1, 8'hE5, "R3 din port0");
        rd_chk(4'h5, 8'hCD, "R3 din port1");
        rd_chk(4'h9, 8'hAB, "R3 din port2");
        rd_chk(4'hB, 8'h01, "R3 din port3");
        @(negedge clk); pin_in = 29'h1F000000;
        idle(3);
        rd_chk(4'hB, 8'h1F, "R3 din port3 upper bits zero");

        // R4: event enables
        @(negedge clk); pin_in = '0;
        idle(4);
        wr(4'h2, 8'hFF); wr(4'h6, 8'h0F);
        rd_chk(4'h2, 8'hFF, "R4 enable port0");
        rd_chk(4'h6, 8'h0F, "R4 enable port1");

        // R5 / R11: rising edges, enables gate set
        @(negedge clk); pin_in = 29'h0000FFFF;
        idle(4);
        rd_chk(4'h3, 8'hFF, "R5 status port0");
        rd_chk(4'h7, 8'h0F, "R11 status port1 masked by enable");
        chk(32'(evt_irq), 1, "R7 irq raised");
        @(negedge clk); pin_in = '0;
        idle(4);
        rd_chk(4'h7, 8'h0F, "R11 falling edge no effect");

        // R6: write-one-to-clear
        wr(4'h3, 8'h0F);
        rd_chk(4'h3, 8'hF0, "R6 partial clear");
        wr(4'h3, 8'h00);
        rd_chk(4'h3, 8'hF0, "R6 zero write no effect");

        // R7: masking keeps status
        wr(4'h2, 8'h00);
        wr(4'h7, 8'hFF);
        #1;
        chk(32'(evt_irq), 0, "R7 irq masked");
        rd_chk(4'h3, 8'hF0, "R7 status kept while masked");

        // R6: set and clear on the same edge, set wins
        wr(4'h2, 8'h01); wr(4'h3, 8'hFF);
        @(negedge clk); pin_in = 29'h1;
        @(negedge clk);
        wr(4'h3, 8'h01);
        rd_chk(4'h3, 8'h01, "R6 set beats clear");
        @(negedge clk); pin_in = '0;

        // R9: unmapped and read-only offsets
        wr(4'hC, 8'h77); wr(4'hF, 8'h77); wr(4'h1, 8'h77); wr(4'hB, 8'h77);
        rd_chk(4'hC, 8'h00, "R9 unmapped read");
        rd_chk(4'hE, 8'h00, "R9 unmapped read high");
        rd_chk(4'h0, 8'hA5, "R9 dout0 untouched");
        rd_chk(4'hA, 8'h1F, "R9 dout3 untouched");
        rd_chk(4'h1, 8'h00, "R9 din unaffected by write");

        // R10: read and write on the same edge
        @(negedge clk);
        bus_addr = 4'h0; bus_wdata = 8'h11; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        #1;
        chk(32'(bus_rdata), 32'hA5, "R10 old value on same-edge write");
        idle(2);
        chk(32'(bus_rdata), 32'hA5, "R10 holds without read");
        rd_chk(4'h0, 8'h11, "R10 new value next read");

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule